// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block keeps an indexed colour table: one entry per possible pixel code, each entry holding an 8-bit red, an 8-bit green and an 8-bit blue intensity. Software fills the table through a small 32-bit write window. One location of the window sets the entry pointer. A second location takes colour bytes, and a three-step sequencer routes them to red, green and blue in turn. Once blue has been stored, the pointer moves to the next entry, so a whole table can be streamed after a single pointer write. The colour byte always travels in the top byte of the 32-bit write word.

On the display side, a pixel code enters a lookup port and the matching 24-bit colour leaves it one clock later. Every stored component also produces a one-cycle update strobe that carries the entry number, so a downstream cache or scan-out stage can track the changes. Reads of the register window always return zero.

Top module: `clut_regport`

## Requirements
- R1: A write at window offset 0x0 sets the entry pointer to write-data bits 31:24 and puts the sequencer in the red phase, whatever phase it was in before.
- R2: Writes at window offset 0x4 store write-data bits 31:24 into the current entry. The first such write fills red, the second green and the third blue. Bits 23:0 of the write data are not used.
- R3: The clock edge that stores blue also advances the entry pointer by one, wrapping from 255 to 0, and sets the sequencer back to the red phase.
- R4: A write at any other offset of the 16-byte window (0x1-0x3, 0x5-0xF) changes no table entry, the pointer or the phase, and raises no update strobe.
- R5: `bus_rdata` is zero at all times.
- R6: After reset, entries 0 to 254 hold 0x000000 and entry 255 holds 0xFFFFFF, the pointer is 0, the phase is red and `pix_rgb` is 0.
- R7: `pix_rgb` is registered. It shows {red, green, blue} (red in bits 23:16, blue in bits 7:0) of the entry that `pix_idx` selected at the previous clock edge. A component stored at edge k shows up in a lookup sampled at edge k+1 or later, not in one sampled at edge k.
- R8: For the cycle after each stored component, `upd_valid` is 1 and `upd_idx` gives the entry that was written. In every other cycle `upd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data; colour or pointer byte in bits 31:24 |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered colour {R,G,B} for the pixel code |
| upd_valid | output | 1 | One-cycle pulse after each component store |
| upd_idx | output | 8 | Entry number that goes with `upd_valid` |

## Verification
The bench builds the block with its default parameters: 256 entries and 8-bit components, placed in the top byte of a 32-bit word. At that size a full sweep takes under a thousand bus writes. This lets the bench check every reset entry, stream all 768 components after a single pointer write, follow the pointer as it wraps from 255 back to 0, and then read back the whole table against an arithmetic colour pattern. It also tries every unused window offset, restarts the sequencer mid-entry, and checks the exact cycle at which a new colour appears on the lookup port.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Order in which the data register fills the components of one entry
  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // One-hot component enable: bit 2 red, bit 1 green, bit 0 blue
  function automatic logic [2:0] phase_enable(input phase_e p);
    case (p)
      PH_RED:  return 3'b100;
      PH_GRN:  return 3'b010;
      PH_BLU:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int COMP_W  = 8,
  parameter int IDX_OFS = 0,
  parameter int DAT_OFS = 4
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              idx_load,
  output logic              data_stb,
  output logic [COMP_W-1:0] wr_byte
);

  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_OFS);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DAT_OFS);

  assign idx_load = bus_we && (bus_addr == IDX_A);
  assign data_stb = bus_we && (bus_addr == DAT_A);
  assign wr_byte  = bus_wdata[DATA_W-1 -: COMP_W];

  // R4: at most one register of the window is selected per access
  always_comb begin
    a_r4_exclusive: assert (!(idx_load && data_stb));
  end

endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_load,
  input  logic              data_stb,
  input  logic [COMP_W-1:0] wr_byte,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [2:0]        comp_we,
  output logic [COMP_W-1:0] comp_val
);

  phase_e phase_q;
  logic   blue_done;

  assign comp_we   = data_stb ? phase_enable(phase_q) : 3'b000;
  assign comp_val  = wr_byte;
  assign blue_done = data_stb && (phase_q == PH_BLU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      phase_q <= PH_RED;
    end else if (idx_load) begin
      cur_idx <= wr_byte[IDX_W-1:0];
      phase_q <= PH_RED;
    end else if (data_stb) begin
      phase_q <= phase_after(phase_q);
      if (blue_done) cur_idx <= cur_idx + 1'b1;
    end
  end

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (cur_idx == $past(wr_byte[IDX_W-1:0])) && (phase_q == PH_RED));

  a_r2_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && phase_q == PH_RED) |=> (phase_q == PH_GRN) && $stable(cur_idx));

  a_r2_green_then_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && phase_q == PH_GRN) |=> (phase_q == PH_BLU) && $stable(cur_idx));

  a_r3_blue_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && phase_q == PH_BLU) |=>
      (phase_q == PH_RED) && (cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_load && !data_stb) |=> $stable(cur_idx) && $stable(phase_q));

  a_r2_one_component: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          comp_we,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [COMP_W-1:0]   wr_val,
  input  logic [IDX_W-1:0]    look_idx,
  output logic [3*COMP_W-1:0] look_rgb,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_idx
);

  localparam int ENTRIES = 1 << IDX_W;

  // Reset colour: the last entry is full white, every other entry black
  function automatic logic [COMP_W-1:0] reset_level(input int entry);
    return (entry == ENTRIES - 1) ? {COMP_W{1'b1}} : '0;
  endfunction

  logic [COMP_W-1:0] plane_out [3];

  // One plane per component; plane 2 is red, plane 0 is blue
  for (genvar c = 0; c < 3; c++) begin : g_plane
    logic [COMP_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++) mem[e] <= reset_level(e);
      end else if (comp_we[c]) begin
        mem[wr_idx] <= wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plane_out[c] <= '0;
      else        plane_out[c] <= mem[look_idx];
    end
  end

  assign look_rgb = {plane_out[2], plane_out[1], plane_out[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_idx   <= '0;
    end else begin
      upd_valid <= |comp_we;
      if (|comp_we) upd_idx <= wr_idx;
    end
  end

  a_r8_strobe_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
    (|comp_we) |=> upd_valid && (upd_idx == $past(wr_idx)));

  a_r8_quiet_without_store: assert property (@(posedge clk) disable iff (!rst_n)
    !(|comp_we) |=> !upd_valid);

  a_r7_lookup_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(look_idx) && comp_we == 3'b000 && $past(comp_we) == 3'b000) |=> $stable(look_rgb));

endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic                upd_valid,
  output logic [IDX_W-1:0]    upd_idx
);

  logic              idx_load;
  logic              data_stb;
  logic [COMP_W-1:0] wr_byte;
  logic [IDX_W-1:0]  cur_idx;
  logic [2:0]        comp_we;
  logic [COMP_W-1:0] comp_val;

  // R5: the window is write-only
  assign bus_rdata = '0;

  clut_bus_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .COMP_W (COMP_W)
  ) i_decode (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .idx_load  (idx_load),
    .data_stb  (data_stb),
    .wr_byte   (wr_byte)
  );

  clut_sequencer #(
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_load (idx_load),
    .data_stb (data_stb),
    .wr_byte  (wr_byte),
    .cur_idx  (cur_idx),
    .comp_we  (comp_we),
    .comp_val (comp_val)
  );

  clut_store #(
    .IDX_W  (IDX_W),
    .COMP_W (COMP_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .comp_we   (comp_we),
    .wr_idx    (cur_idx),
    .wr_val    (comp_val),
    .look_idx  (pix_idx),
    .look_rgb  (pix_rgb),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx)
  );

  a_r4_no_strobe_on_other_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we || (bus_addr != ADDR_W'(4))) |=> !upd_valid);

endmodule

// File: tb/test_clut_regport.sv
module test_clut_regport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        upd_valid;
  logic [7:0]  upd_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] m_idx;
  int         m_ph;

  always #4 clk = ~clk;

  clut_regport i_clut_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .pix_rgb   (pix_rgb),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx)
  );

  function automatic logic [7:0] pat(input int e, input int c, input int seed);
    return 8'((e * 37 + c * 91 + seed * 13 + 5) & 255);
  endfunction

  function automatic logic [23:0] exp_rgb(input int e);
    return {mr[e], mg[e], mb[e]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; the colour byte goes in bits 31:24 with noise below
  task automatic bus_wr(input logic [3:0] a, input logic [7:0] b);
    bit         exp_upd;
    logic [7:0] exp_uidx;
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = {b, 24'hC3A55A};
    exp_upd   = (a == 4'h4);
    exp_uidx  = m_idx;
    if (a == 4'h0) begin
      m_idx = b;
      m_ph  = 0;
    end else if (a == 4'h4) begin
      case (m_ph)
        0: mr[m_idx] = b;
        1: mg[m_idx] = b;
        default: mb[m_idx] = b;
      endcase
      if (m_ph == 2) begin
        m_idx = m_idx + 8'd1;
        m_ph  = 0;
      end else begin
        m_ph = m_ph + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    if (exp_upd) begin
      chk(upd_valid == 1'b1, "R8 strobe after store", 32'(upd_valid), 32'd1);
      chk(upd_idx == exp_uidx, "R8/R3 strobe entry", 32'(upd_idx), 32'(exp_uidx));
    end else begin
      chk(upd_valid == 1'b0, "R4/R8 no strobe", 32'(upd_valid), 32'd0);
    end
    chk(bus_rdata == 32'd0, "R5 read data zero", bus_rdata, 32'd0);
  endtask

  task automatic look(input int e, input string req);
    pix_idx = 8'(e);
    @(posedge clk);
    @(negedge clk);
    chk(pix_rgb == exp_rgb(e), req, 32'(pix_rgb), 32'(exp_rgb(e)));
  endtask

  task automatic sweep(input string req);
    for (int e = 0; e < 256; e++) look(e, req);
  endtask

  initial begin
    logic [23:0] old_rgb;
    for (int e = 0; e < 256; e++) begin
      mr[e] = (e == 255) ? 8'hFF : 8'h00;
      mg[e] = mr[e];
      mb[e] = mr[e];
    end
    m_idx = '0;
    m_ph  = 0;

    repeat (3) @(negedge clk);
    chk(pix_rgb == 24'h0, "R6 lookup output in reset", 32'(pix_rgb), 32'h0);
    chk(upd_valid == 1'b0, "R6 no strobe in reset", 32'(upd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rdata == 32'd0, "R5 read data after reset", bus_rdata, 32'd0);

    // R6: whole reset table
    sweep("R6 reset table");

    // R6: pointer starts at 0, red phase (no pointer write before data)
    bus_wr(4'h4, 8'h21);
    bus_wr(4'h4, 8'h22);
    bus_wr(4'h4, 8'h23);
    look(0, "R6 pointer 0 at reset");

    // R2/R3: stream all entries after one pointer write, wrap 255 -> 0
    bus_wr(4'h0, 8'h00);
    for (int e = 0; e < 256; e++)
      for (int c = 0; c < 3; c++) bus_wr(4'h4, pat(e, c, 1));
    chk(m_idx == 8'd0, "R3 model wrapped", 32'(m_idx), 32'd0);
    for (int c = 0; c < 3; c++) bus_wr(4'h4, pat(0, c, 2));
    sweep("R2/R3 streamed table");

    // R4: unused offsets in the middle of an entry
    bus_wr(4'h0, 8'd77);
    bus_wr(4'h4, 8'hA1);
    for (int a = 1; a < 16; a++)
      if (a != 4) bus_wr(4'(a), 8'(a * 17));
    bus_wr(4'h4, 8'hA2);
    bus_wr(4'h4, 8'hA3);
    look(77, "R4 entry after ignored writes");
    look(78, "R4 next entry untouched");
    for (int a = 1; a < 16; a++)
      if (a != 4) look(a * 17, "R4 offset value not used as pointer");
    bus_wr(4'h4, 8'hB1);
    bus_wr(4'h4, 8'hB2);
    bus_wr(4'h4, 8'hB3);
    look(78, "R3 pointer advanced past 77");

    // R1: pointer rewrite mid-entry restarts at red
    bus_wr(4'h0, 8'd10);
    bus_wr(4'h4, 8'h5E);
    bus_wr(4'h0, 8'd20);
    bus_wr(4'h4, 8'h61);
    bus_wr(4'h4, 8'h62);
    bus_wr(4'h4, 8'h63);
    look(10, "R1 partial entry keeps green/blue");
    look(20, "R1 restarted entry");
    bus_wr(4'h0, 8'd255);
    bus_wr(4'h4, 8'h01);
    bus_wr(4'h4, 8'h02);
    bus_wr(4'h4, 8'h03);
    bus_wr(4'h4, 8'h0A);
    look(255, "R1 pointer 255");
    look(0, "R3 wrap after pointer 255");

    // R7: new colour visible one edge after the store edge
    pix_idx = 8'd50;
    @(posedge clk);
    @(negedge clk);
    bus_wr(4'h0, 8'd50);
    old_rgb = exp_rgb(50);
    bus_wr(4'h4, 8'hEE);
    chk(pix_rgb == old_rgb, "R7 store edge still old", 32'(pix_rgb), 32'(old_rgb));
    @(posedge clk);
    @(negedge clk);
    chk(pix_rgb == exp_rgb(50), "R7 next edge new", 32'(pix_rgb), 32'(exp_rgb(50)));
    chk(upd_valid == 1'b0, "R8 single-cycle strobe", 32'(upd_valid), 32'd0);

    sweep("R7 final table");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule